// File: doc/BRIEF.md
# Privileged Processor Status Register

This block holds the 16-bit status word of a small CPU core. The low byte carries the condition flags, which compare and add/subtract operations update, plus a trace-enable bit. The high byte carries mode bits that only supervisor code may change: user mode, stack-pointer choice, trace pending, interrupt enable and block-transfer activity. The core presents an operation code with two operands each cycle. The block evaluates compares and add/subtract carries itself and folds the results into the flags.

Around interrupts the core pulses an acknowledge strobe. The block then clears the mode bits that entry must clear, while the core pushes the old word from `psr_o` onto its stack. A later return strobe loads the popped word back in full. A software write port with byte enables lets programs update the register. A user-mode attempt on the high byte is dropped and reported by a one-cycle fault pulse. The block also derives the stack select, interrupt acceptance, single-shot trace trap and an active-low block-transfer indicator.

Top module: `proc_status_reg`

## Requirements
- R1: After reset, `psr_o` is 0, `bpu_n_o` is 1, and `sp_sel_o`, `user_o`, `trace_trap_o` and `priv_fault_o` are 0.
- R2: A write with `wr_en` loads `wr_data[7:0]` into bits 7:0 when `wr_be[0]` is 1. It loads `wr_data[15:8]` into bits 15:8 when `wr_be[1]` is 1 and the user bit (bit 8) is 0. The new value is visible in the next cycle.
- R3: When the user bit is 1, a write with `wr_be[1]` leaves bits 15:8 unchanged, still writes the low byte if `wr_be[0]` is 1, and raises `priv_fault_o` for exactly the next cycle.
- R4: With `op_sel`=1 (integer compare), bit 6 becomes (src2==src1), bit 7 becomes (src2<src1 signed) and bit 2 becomes (src2<src1 unsigned).
- R5: With `op_sel`=2 (float compare), bit 6 takes `fcmp_eq`, bit 7 takes `fcmp_lt`, and bit 2 is cleared.
- R6: `op_sel` 3/4 (add / add with carry) set bit 0 to the carry out of src1+src2+cin. `op_sel` 5/6 (subtract / subtract with borrow) set bit 0 to the borrow of src2-src1-bin. In both cases bit 5 gets signed overflow. For op 4 and 6, cin/bin is the current bit 0; otherwise it is 0. `carry_o` shows bit 0.
- R7: `irq_ack` clears bits 12 (block), 11 (interrupt enable), 10 (trace pending), 9 (stack select) and 8 (user), keeps every other bit, and so drives `bpu_n_o` high.
- R8: `reti` (without `irq_ack`) loads `reti_val` into the whole register.
- R9: `sp_sel_o` equals bit 9 (0 selects stack pointer 0, 1 selects stack pointer 1), and `user_o` equals bit 8.
- R10: `instr_start` copies the trace bit (bit 1) into the pending bit (bit 10). `instr_done` clears pending, and if pending was set (or set in the same cycle) `trace_trap_o` pulses for one cycle. A trap therefore fires at most once per instruction.
- R11: `irq_take_o` = `nmi_req` OR (`irq_req` AND bit 11), combinationally.
- R12: `blk_start` sets bit 12 and `blk_done` clears it, with start winning. `bpu_n_o` is the inverse of bit 12.
- R13: Priority is `irq_ack` over `reti` over the write port over the operation, block and trace updates. A fault is reported even when the write is overridden.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | 0 none, 1 int compare, 2 float compare, 3 add, 4 add-carry, 5 sub, 6 sub-borrow |
| src1 | input | DATA_W | First operand |
| src2 | input | DATA_W | Second operand |
| fcmp_eq | input | 1 | Float compare: operands equal |
| fcmp_lt | input | 1 | Float compare: second less than first |
| wr_en | input | 1 | Software write strobe |
| wr_be | input | 2 | Byte enables, bit 1 = high byte |
| wr_data | input | 16 | Write data |
| irq_ack | input | 1 | Interrupt/trap acknowledged |
| reti | input | 1 | Return from interrupt |
| reti_val | input | 16 | Word popped from the stack |
| instr_start | input | 1 | Instruction begins |
| instr_done | input | 1 | Instruction completes |
| blk_start | input | 1 | Extended block transfer begins |
| blk_done | input | 1 | Extended block transfer ends |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| psr_o | output | 16 | Register contents |
| carry_o | output | 1 | Carry bit for chained arithmetic |
| user_o | output | 1 | User mode |
| sp_sel_o | output | 1 | Stack pointer select |
| irq_take_o | output | 1 | Interrupt accepted |
| trace_trap_o | output | 1 | Trace trap request pulse |
| priv_fault_o | output | 1 | Privilege violation pulse |
| bpu_n_o | output | 1 | Block transfer active, low |

## Verification
Compares are driven with operand pairs chosen to separate the three flags. Equal values set only Z. 0x8000 against 1 makes N set while L stays clear, and 1 against 0xFFFF gives the opposite, so swapped signed/unsigned logic shows up. Add and subtract are tried at the carry edge, 0xFFFF+1, and at the overflow edge, 0x7FFF+1. The carry-chained variants run with a stored carry, which exposes a missing carry-in. Writes go in from both modes with each byte-enable pattern. Random cycles then mix strobes that collide, such as ack with return and write with compare, to test the priority order against a bench model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 16;
  localparam int BYTE_W = 8;

  localparam int B_CY  = 0;
  localparam int B_TRC = 1;
  localparam int B_LTU = 2;
  localparam int B_OVF = 5;
  localparam int B_EQ  = 6;
  localparam int B_LTS = 7;
  localparam int B_USR = 8;
  localparam int B_STK = 9;
  localparam int B_PND = 10;
  localparam int B_IEN = 11;
  localparam int B_BLK = 12;

  localparam logic [PSR_W-1:0] IRQ_CLR_MASK =
    (PSR_W'(1) << B_BLK) | (PSR_W'(1) << B_IEN) | (PSR_W'(1) << B_PND) |
    (PSR_W'(1) << B_STK) | (PSR_W'(1) << B_USR);

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CMPI = 3'd1,
    OP_CMPF = 3'd2,
    OP_ADD  = 3'd3,
    OP_ADDC = 3'd4,
    OP_SUB  = 3'd5,
    OP_SUBC = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef struct packed {
    logic c_we;
    logic c;
    logic f_we;
    logic f;
    logic z_we;
    logic z;
    logic n_we;
    logic n;
    logic l_we;
    logic l;
  } flag_upd_t;
endpackage

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e                op,
  input  logic [DATA_W-1:0]  src1,
  input  logic [DATA_W-1:0]  src2,
  input  logic               fcmp_eq,
  input  logic               fcmp_lt,
  input  logic               cy_in,
  output flag_upd_t          upd
);
  localparam int MSB = DATA_W - 1;

  function automatic logic add_carry(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                     input logic ci);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
    return s[DATA_W];
  endfunction

  function automatic logic add_ovf(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                   input logic ci);
    logic [DATA_W-1:0] r;
    r = a + b + {{(DATA_W-1){1'b0}}, ci};
    return (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
  endfunction

  // minuend m, subtrahend s: m - s - bi
  function automatic logic sub_borrow(input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] s,
                                      input logic bi);
    return {1'b0, m} < ({1'b0, s} + {{DATA_W{1'b0}}, bi});
  endfunction

  function automatic logic sub_ovf(input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] s,
                                   input logic bi);
    logic [DATA_W-1:0] r;
    r = m - s - {{(DATA_W-1){1'b0}}, bi};
    return (m[MSB] != s[MSB]) && (r[MSB] != m[MSB]);
  endfunction

  logic chain_in;
  assign chain_in = ((op == OP_ADDC) || (op == OP_SUBC)) ? cy_in : 1'b0;

  always_comb begin
    upd = '0;
    unique case (op)
      OP_CMPI: begin
        upd.z_we = 1'b1; upd.z = (src2 == src1);
        upd.n_we = 1'b1; upd.n = ($signed(src2) < $signed(src1));
        upd.l_we = 1'b1; upd.l = (src2 < src1);
      end
      OP_CMPF: begin
        upd.z_we = 1'b1; upd.z = fcmp_eq;
        upd.n_we = 1'b1; upd.n = fcmp_lt;
        upd.l_we = 1'b1; upd.l = 1'b0;
      end
      OP_ADD, OP_ADDC: begin
        upd.c_we = 1'b1; upd.c = add_carry(src1, src2, chain_in);
        upd.f_we = 1'b1; upd.f = add_ovf(src1, src2, chain_in);
      end
      OP_SUB, OP_SUBC: begin
        upd.c_we = 1'b1; upd.c = sub_borrow(src2, src1, chain_in);
        upd.f_we = 1'b1; upd.f = sub_ovf(src2, src1, chain_in);
      end
      default: upd = '0;
    endcase
  end
endmodule

// File: rtl/psr_trace_unit.sv
module psr_trace_unit (
  input  logic trc_en,
  input  logic pend_cur,
  input  logic instr_start,
  input  logic instr_done,
  output logic pend_nxt,
  output logic trap_evt
);
  logic pend_eff;
  assign pend_eff = pend_cur | (instr_start & trc_en);

  always_comb begin
    if (instr_done)       pend_nxt = 1'b0;
    else if (instr_start) pend_nxt = trc_en;
    else                  pend_nxt = pend_cur;
  end

  assign trap_evt = instr_done & pend_eff;
endmodule

// File: rtl/psr_write_guard.sv
module psr_write_guard
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0]  cur_word,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [PSR_W-1:0]  wr_data,
  output logic [PSR_W-1:0]  merged,
  output logic              viol_evt
);
  logic lo_we, hi_try, hi_we;
  assign lo_we  = wr_en & wr_be[0];
  assign hi_try = wr_en & wr_be[1];
  assign hi_we  = hi_try & ~user_mode;

  assign merged[BYTE_W-1:0]     = lo_we ? wr_data[BYTE_W-1:0]     : cur_word[BYTE_W-1:0];
  assign merged[PSR_W-1:BYTE_W] = hi_we ? wr_data[PSR_W-1:BYTE_W] : cur_word[PSR_W-1:BYTE_W];
  assign viol_evt = hi_try & user_mode;
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic              fcmp_eq,
  input  logic              fcmp_lt,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  input  logic              irq_ack,
  input  logic              reti,
  input  logic [15:0]       reti_val,
  input  logic              instr_start,
  input  logic              instr_done,
  input  logic              blk_start,
  input  logic              blk_done,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic [15:0]       psr_o,
  output logic              carry_o,
  output logic              user_o,
  output logic              sp_sel_o,
  output logic              irq_take_o,
  output logic              trace_trap_o,
  output logic              priv_fault_o,
  output logic              bpu_n_o
);
  logic [PSR_W-1:0] psr_q, psr_d;
  logic [PSR_W-1:0] after_ops, after_wr;
  flag_upd_t        flag_upd;
  logic             pend_nxt, trap_evt, viol_evt;
  logic             trap_q, fault_q;
  logic             irq_entry, irq_return;

  assign irq_entry  = irq_ack;
  assign irq_return = reti & ~irq_ack;

  psr_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .op      (op_e'(op_sel)),
    .src1    (src1),
    .src2    (src2),
    .fcmp_eq (fcmp_eq),
    .fcmp_lt (fcmp_lt),
    .cy_in   (psr_q[B_CY]),
    .upd     (flag_upd)
  );

  psr_trace_unit u_trace (
    .trc_en      (psr_q[B_TRC]),
    .pend_cur    (psr_q[B_PND]),
    .instr_start (instr_start),
    .instr_done  (instr_done),
    .pend_nxt    (pend_nxt),
    .trap_evt    (trap_evt)
  );

  always_comb begin
    after_ops = psr_q;
    if (flag_upd.c_we) after_ops[B_CY]  = flag_upd.c;
    if (flag_upd.f_we) after_ops[B_OVF] = flag_upd.f;
    if (flag_upd.z_we) after_ops[B_EQ]  = flag_upd.z;
    if (flag_upd.n_we) after_ops[B_LTS] = flag_upd.n;
    if (flag_upd.l_we) after_ops[B_LTU] = flag_upd.l;
    if (blk_done)      after_ops[B_BLK] = 1'b0;
    if (blk_start)     after_ops[B_BLK] = 1'b1;
    after_ops[B_PND] = pend_nxt;
  end

  psr_write_guard u_guard (
    .cur_word  (after_ops),
    .user_mode (psr_q[B_USR]),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .merged    (after_wr),
    .viol_evt  (viol_evt)
  );

  always_comb begin
    if (irq_entry)       psr_d = psr_q & ~IRQ_CLR_MASK;
    else if (irq_return) psr_d = reti_val;
    else                 psr_d = after_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_q   <= '0;
      trap_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      psr_q   <= psr_d;
      trap_q  <= trap_evt;
      fault_q <= viol_evt;
    end
  end

  assign psr_o        = psr_q;
  assign carry_o      = psr_q[B_CY];
  assign user_o       = psr_q[B_USR];
  assign sp_sel_o     = psr_q[B_STK];
  assign bpu_n_o      = ~psr_q[B_BLK];
  assign irq_take_o   = nmi_req | (irq_req & psr_q[B_IEN]);
  assign trace_trap_o = trap_q;
  assign priv_fault_o = fault_q;

  // R3: user-mode write to the high byte leaves it frozen
  a_r3_user_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && psr_q[B_USR] && !irq_ack && !reti && !blk_start && !blk_done
     && !instr_start && !instr_done)
    |=> psr_q[PSR_W-1:BYTE_W] == $past(psr_q[PSR_W-1:BYTE_W]));

  // R3: a fault pulse always follows a user high-byte attempt
  a_r3_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault_o |-> $past(wr_en && wr_be[1] && psr_q[B_USR]));

  // R7: interrupt entry clears the mode bits and releases the block indicator
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> ((psr_o & IRQ_CLR_MASK) == '0) && bpu_n_o && !sp_sel_o && !user_o);

  // R8: return restores the popped word
  a_r8_reti_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> psr_o == $past(reti_val));

  // R5: float compare leaves the unsigned-less flag clear
  a_r5_flt_ltu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2 && !irq_ack && !reti && !(wr_en && wr_be[0])) |=> !psr_o[B_LTU]);

  // R10: pending is gone once an instruction completes
  a_r10_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && !reti && !(wr_en && wr_be[1])) |=> !psr_o[B_PND]);

  // R12: block start drives the indicator low
  a_r12_blk_active: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !irq_ack && !reti && !(wr_en && wr_be[1] && !psr_q[B_USR])) |=> !bpu_n_o);
endmodule

// File: tb/proc_status_reg_tb.sv
`timescale 1ns/1ps
module proc_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [15:0] src1, src2;
  logic        fcmp_eq, fcmp_lt;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic        irq_ack, reti;
  logic [15:0] reti_val;
  logic        instr_start, instr_done, blk_start, blk_done, irq_req, nmi_req;
  logic [15:0] psr_o;
  logic        carry_o, user_o, sp_sel_o, irq_take_o, trace_trap_o, priv_fault_o, bpu_n_o;

  int total = 0;
  int bad = 0;
  logic [15:0] model;
  logic [15:0] exp_psr;
  logic        exp_trap, exp_fault;

  always #4 clk = ~clk;

  proc_status_reg #(.DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src1(src1), .src2(src2),
    .fcmp_eq(fcmp_eq), .fcmp_lt(fcmp_lt), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .irq_ack(irq_ack), .reti(reti), .reti_val(reti_val),
    .instr_start(instr_start), .instr_done(instr_done), .blk_start(blk_start),
    .blk_done(blk_done), .irq_req(irq_req), .nmi_req(nmi_req), .psr_o(psr_o),
    .carry_o(carry_o), .user_o(user_o), .sp_sel_o(sp_sel_o), .irq_take_o(irq_take_o),
    .trace_trap_o(trace_trap_o), .priv_fault_o(priv_fault_o), .bpu_n_o(bpu_n_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_sel = 3'd0; src1 = '0; src2 = '0; fcmp_eq = 1'b0; fcmp_lt = 1'b0;
    wr_en = 1'b0; wr_be = 2'b00; wr_data = '0; irq_ack = 1'b0; reti = 1'b0;
    reti_val = '0; instr_start = 1'b0; instr_done = 1'b0; blk_start = 1'b0;
    blk_done = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
  endtask

  // Bench restatement of the requirements using plain integer arithmetic.
  task automatic predict();
    logic [15:0] n;
    int s, sv, ci;
    n = model;
    ci = ((op_sel == 3'd4) || (op_sel == 3'd6)) ? int'(model[0]) : 0;
    case (op_sel)
      3'd1: begin
        n[6] = (src2 == src1);
        n[7] = (int'($signed(src2)) < int'($signed(src1)));
        n[2] = (int'(src2) < int'(src1));
      end
      3'd2: begin n[6] = fcmp_eq; n[7] = fcmp_lt; n[2] = 1'b0; end
      3'd3, 3'd4: begin
        s  = int'(src1) + int'(src2) + ci;
        sv = int'($signed(src1)) + int'($signed(src2)) + ci;
        n[0] = (s > 65535);
        n[5] = (sv > 32767) || (sv < -32768);
      end
      3'd5, 3'd6: begin
        s  = int'(src2) - int'(src1) - ci;
        sv = int'($signed(src2)) - int'($signed(src1)) - ci;
        n[0] = (s < 0);
        n[5] = (sv > 32767) || (sv < -32768);
      end
      default: ;
    endcase
    if (blk_done)  n[12] = 1'b0;
    if (blk_start) n[12] = 1'b1;
    if (instr_done)       n[10] = 1'b0;
    else if (instr_start) n[10] = model[1];
    exp_trap = instr_done && (model[10] || (instr_start && model[1]));
    if (wr_en && wr_be[0]) n[7:0] = wr_data[7:0];
    if (wr_en && wr_be[1] && !model[8]) n[15:8] = wr_data[15:8];
    exp_fault = wr_en && wr_be[1] && model[8];
    if (reti) n = reti_val;
    if (irq_ack) n = model & 16'hE0FF;
    exp_psr = n;
  endtask

  // Called right after inputs are driven at a falling edge.
  task automatic step(input string tag);
    predict();
    #1;
    chk("R11", "irq_take", {31'd0, irq_take_o}, {31'd0, nmi_req | (irq_req & model[11])});
    @(posedge clk);
    @(negedge clk);
    model = exp_psr;
    chk(tag, "psr", {16'd0, psr_o}, {16'd0, exp_psr});
    chk(tag, "trap", {31'd0, trace_trap_o}, {31'd0, exp_trap});
    chk(tag, "fault", {31'd0, priv_fault_o}, {31'd0, exp_fault});
    chk("R12", "bpu_n", {31'd0, bpu_n_o}, {31'd0, ~exp_psr[12]});
    chk("R9", "sp_sel", {31'd0, sp_sel_o}, {31'd0, exp_psr[9]});
    chk("R9", "user", {31'd0, user_o}, {31'd0, exp_psr[8]});
    chk("R6", "carry_o", {31'd0, carry_o}, {31'd0, exp_psr[0]});
    idle_inputs();
  endtask

  task automatic do_write(input logic [1:0] be, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    step(tag);
  endtask

  task automatic do_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    op_sel = op; src1 = a; src2 = b;
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    // R1 reset state
    chk("R1", "psr", {16'd0, psr_o}, 32'd0);
    chk("R1", "bpu_n", {31'd0, bpu_n_o}, 32'd1);
    chk("R1", "sp_sel", {31'd0, sp_sel_o}, 32'd0);
    chk("R1", "user", {31'd0, user_o}, 32'd0);
    chk("R1", "trap", {31'd0, trace_trap_o}, 32'd0);
    chk("R1", "fault", {31'd0, priv_fault_o}, 32'd0);

    do_write(2'b01, 16'h12A5, "R2");
    do_write(2'b10, 16'h0A5A, "R2");
    irq_req = 1'b1; step("R11");
    do_write(2'b10, 16'h0100, "R2");
    do_write(2'b11, 16'hFEC3, "R3");
    do_write(2'b10, 16'h0000, "R3");
    reti = 1'b1; reti_val = 16'h0000; step("R8");

    do_op(3'd1, 16'h1234, 16'h1234, "R4");
    do_op(3'd1, 16'h0001, 16'h8000, "R4");
    do_op(3'd1, 16'hFFFF, 16'h0001, "R4");
    fcmp_eq = 1'b1; fcmp_lt = 1'b1; do_op(3'd2, 16'h0, 16'h0, "R5");
    do_op(3'd3, 16'hFFFF, 16'h0001, "R6");
    do_op(3'd4, 16'h0000, 16'h0000, "R6");
    do_op(3'd5, 16'h0002, 16'h0001, "R6");
    do_op(3'd6, 16'h0000, 16'h0005, "R6");
    do_op(3'd3, 16'h7FFF, 16'h0001, "R6");

    do_write(2'b01, 16'h0002, "R10");
    instr_start = 1'b1; step("R10");
    instr_done = 1'b1; step("R10");
    instr_done = 1'b1; step("R10");
    instr_start = 1'b1; instr_done = 1'b1; step("R10");
    do_write(2'b01, 16'h0000, "R10");

    blk_start = 1'b1; step("R12");
    blk_start = 1'b1; blk_done = 1'b1; step("R12");
    blk_done = 1'b1; step("R12");
    do_write(2'b10, 16'h1F00, "R7");
    irq_ack = 1'b1; step("R7");
    nmi_req = 1'b1; step("R11");

    irq_ack = 1'b1; reti = 1'b1; reti_val = 16'hFFFF; step("R13");
    wr_en = 1'b1; wr_be = 2'b01; wr_data = 16'h00F0; op_sel = 3'd1; src1 = 16'h5;
    src2 = 16'h5; step("R13");
    reti = 1'b1; reti_val = 16'h0100; wr_en = 1'b1; wr_be = 2'b11; wr_data = 16'h0E0E;
    step("R13");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      op_sel = 3'($urandom % 8);
      src1 = 16'($urandom); src2 = 16'($urandom);
      if (($urandom % 4) == 0) src2 = src1;
      fcmp_eq = 1'($urandom); fcmp_lt = 1'($urandom);
      wr_en = (($urandom % 4) == 0);
      wr_be = 2'($urandom); wr_data = 16'($urandom);
      irq_ack = (($urandom % 16) == 0);
      reti = (($urandom % 16) == 0);
      reti_val = 16'($urandom);
      instr_start = (($urandom % 4) == 0);
      instr_done = (($urandom % 4) == 0);
      blk_start = (($urandom % 8) == 0);
      blk_done = (($urandom % 8) == 0);
      irq_req = 1'($urandom); nmi_req = (($urandom % 8) == 0);
      step("R13");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule